// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the frequency a phase-locked loop produces, given the reference frequency and the divider settings read back from its control words. Three fields are taken from the first divider word: a feedback multiplier, a pre-divider and a post-divider. A second word supplies a signed 16-bit fractional term. The post-divider is a power-of-two exponent that scales the pre-divider. In fractional mode the fraction is added into the multiplier in units of 1/65536.

A one-cycle `start` strobe latches the inputs. The block builds a 64-bit numerator and a divisor in the same cycle. A restoring shift-subtract divider then produces one quotient bit per clock. When the last bit is done, `valid` pulses for one cycle and `freq_out` carries the result. `freq_out` holds that value until the next computation is accepted. A pre-divider of zero raises `err` instead of starting a division.

Top module: `pll_rate_calc`

## Requirements
- R1: Fields are read from the first divider word as follows: multiplier from bits 21:12 (unsigned), pre-divider from bits 9:4 (unsigned), post-divider from bits 2:0 (unsigned). The fraction k is bits 15:0 of the second word, read as a two's-complement value.
- R2: With `frac_mode` low, `freq_out` equals floor(ref × multiplier / (pre-divider × 2^post-divider)).
- R3: With `frac_mode` high, `freq_out` equals ref × (multiplier × 65536 + k) / (pre-divider × 65536 × 2^post-divider), truncated toward zero.
- R4: When multiplier × 65536 + k is negative, `freq_out` is the two's-complement 64-bit value of the quotient truncated toward zero (for example −1.5 gives −1, all ones).
- R5: `valid` is high for exactly one cycle. It rises 64 clock edges after the edge that accepted `start`.
- R6: A `start` accepted with a pre-divider of zero sets `err` for the single cycle after that edge. No `valid` follows, and `freq_out` is unchanged.
- R7: A `start` that arrives while a division is in progress is ignored. The running result and its timing are unaffected, and no extra `valid` follows.
- R8: While idle, `freq_out` holds the last result until another computation is accepted.
- R9: While reset is held, `valid` and `err` are low and `freq_out` is zero.
- R10: A `start` in the same cycle that `valid` is high is accepted. The next result arrives 64 edges later.
- R11: In integer mode the second divider word has no effect on the result.
- R12: Bits of either divider word outside the fields named in R1 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a computation; sampled when idle |
| frac_mode | input | 1 | 1 = add the fractional term, 0 = integer mode |
| ref_freq | input | REF_W | Reference frequency, unsigned |
| div_word0 | input | 32 | Divider word holding multiplier, pre-divider and post-divider |
| div_word1 | input | 32 | Divider word holding the signed fraction in its low 16 bits |
| freq_out | output | Q_W | Computed frequency, two's complement |
| valid | output | 1 | One-cycle strobe: `freq_out` is new |
| err | output | 1 | One-cycle strobe: pre-divider was zero |

## Verification
The completion of one division and the acceptance of the next can land in the same cycle. A `start` is raised exactly in the cycle where `valid` is high. The bench then checks two things: `freq_out` still shows the finished result in that cycle, and the second result appears precisely 64 edges later with its own value. The other collision is a `start` in the middle of a division. There the bench checks that the first result still arrives on its original edge, and that no second `valid` ever follows.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  localparam int WORD_W   = 32;
  localparam int MUL_W    = 10;
  localparam int MUL_LSB  = 12;
  localparam int PRE_W    = 6;
  localparam int PRE_LSB  = 4;
  localparam int POST_W   = 3;
  localparam int POST_LSB = 0;
  localparam int FRAC_W   = 16;
  localparam int FRAC_LSB = 0;

  // signed width of multiplier*2^FRAC_W + fraction
  localparam int MK_W  = MUL_W + FRAC_W + 1;
  // divisor width: pre-divider scaled by 2^FRAC_W, then by the largest post shift
  localparam int DEN_W = PRE_W + FRAC_W + (2 ** POST_W) - 1;

  typedef struct packed {
    logic [MUL_W-1:0]         mul;
    logic [PRE_W-1:0]         pre;
    logic [POST_W-1:0]        post;
    logic signed [FRAC_W-1:0] frac;
  } pll_fields_t;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_calc_pkg::*;
(
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic              frac_mode,
  output pll_fields_t       fields
);

  logic unused_bits;

  always_comb begin
    fields.mul  = word0[MUL_LSB +: MUL_W];
    fields.pre  = word0[PRE_LSB +: PRE_W];
    fields.post = word0[POST_LSB +: POST_W];
    // integer mode behaves as fractional mode with a zero fraction
    if (frac_mode) begin
      fields.frac = word1[FRAC_LSB +: FRAC_W];
    end else begin
      fields.frac = '0;
    end
  end

  assign unused_bits = ^{word0, word1};

endmodule

// File: rtl/pll_operand_prep.sv
module pll_operand_prep
  import pll_calc_pkg::*;
#(
  parameter int REF_W = 32,
  parameter int NUM_W = 64
) (
  input  logic [REF_W-1:0] ref_freq,
  input  pll_fields_t      fields,
  output logic [NUM_W-1:0] num_mag,
  output logic [DEN_W-1:0] den,
  output logic             neg,
  output logic             pre_zero
);

  logic signed [MK_W-1:0] mul_scaled;
  logic signed [MK_W-1:0] frac_ext;
  logic signed [MK_W-1:0] mk;
  logic [MK_W-1:0]        mk_mag;
  logic [DEN_W-1:0]       den_base;

  always_comb begin
    mul_scaled = $signed({1'b0, fields.mul, {FRAC_W{1'b0}}});
    frac_ext   = $signed({{(MK_W-FRAC_W){fields.frac[FRAC_W-1]}}, fields.frac});
    mk         = mul_scaled + frac_ext;
    neg        = mk[MK_W-1];
    if (neg) begin
      mk_mag = MK_W'(-mk);
    end else begin
      mk_mag = MK_W'(mk);
    end
    num_mag  = NUM_W'(ref_freq) * NUM_W'(mk_mag);
    den_base = DEN_W'({fields.pre, {FRAC_W{1'b0}}});
    den      = den_base << fields.post;
    pre_zero = (fields.pre == '0);
  end

endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int N_W = 64,
  parameter int D_W = 29
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quo
);

  localparam int CNT_W = $clog2(N_W + 1);

  logic [N_W-1:0]   acc_q,  acc_d;
  logic [D_W-1:0]   rem_q,  rem_d;
  logic [D_W-1:0]   den_q;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             step_en;

  logic [D_W:0]     trial;
  logic [D_W:0]     diff;
  logic             take_sub;

  assign step_en = load | busy_q;

  // next-state
  always_comb begin
    trial    = {rem_q, acc_q[N_W-1]};
    take_sub = (trial >= {1'b0, den_q});
    diff     = trial - {1'b0, den_q};

    acc_d  = acc_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;

    if (load) begin
      acc_d  = num;
      rem_d  = '0;
      cnt_d  = CNT_W'(N_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      acc_d = {acc_q[N_W-2:0], take_sub};
      if (take_sub) begin
        rem_d = diff[D_W-1:0];
      end else begin
        rem_d = trial[D_W-1:0];
      end
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (step_en) begin
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q <= '0;
    end else if (load) begin
      den_q <= den;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = acc_q;

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_calc_pkg::*;
#(
  parameter int REF_W = 32,
  parameter int Q_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              frac_mode,
  input  logic [REF_W-1:0]  ref_freq,
  input  logic [WORD_W-1:0] div_word0,
  input  logic [WORD_W-1:0] div_word1,
  output logic [Q_W-1:0]    freq_out,
  output logic              valid,
  output logic              err
);

  logic           rst_sync_n;
  pll_fields_t    fields;
  logic [Q_W-1:0] num_mag;
  logic [DEN_W-1:0] den;
  logic           neg_w;
  logic           pre_zero;
  logic           busy_w;
  logic           done_w;
  logic [Q_W-1:0] quo;

  logic           accept;
  logic           load;
  logic           err_d,  err_q;
  logic           neg_q;

  pll_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pll_field_decode u_dec (
    .word0     (div_word0),
    .word1     (div_word1),
    .frac_mode (frac_mode),
    .fields    (fields)
  );

  pll_operand_prep #(.REF_W(REF_W), .NUM_W(Q_W)) u_prep (
    .ref_freq (ref_freq),
    .fields   (fields),
    .num_mag  (num_mag),
    .den      (den),
    .neg      (neg_w),
    .pre_zero (pre_zero)
  );

  pll_restoring_div #(.N_W(Q_W), .D_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .num   (num_mag),
    .den   (den),
    .busy  (busy_w),
    .done  (done_w),
    .quo   (quo)
  );

  always_comb begin
    accept = start & ~busy_w;
    load   = accept & ~pre_zero;
    err_d  = accept & pre_zero;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      neg_q <= 1'b0;
    end else if (load) begin
      neg_q <= neg_w;
    end
  end

  // sign restored on the magnitude quotient: truncation toward zero
  assign freq_out = neg_q ? (~quo + Q_W'(1)) : quo;
  assign valid    = done_w;
  assign err      = err_q;

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk
  import pll_calc_pkg::*;
#(
  parameter int Q_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] div_word0,
  input logic              busy,
  input logic              valid,
  input logic              err,
  input logic [Q_W-1:0]    freq_out
);

  localparam int LAT_W = $clog2(Q_W + 1) + 1;

  logic [LAT_W-1:0] lat_q;
  logic             unused_word;

  assign unused_word = ^div_word0;

  // edges since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (start && !busy) begin
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + LAT_W'(1);
    end
  end

  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (lat_q == LAT_W'(Q_W)));

  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start && (div_word0[PRE_LSB +: PRE_W] == '0)));

  a_r6_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);

  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(freq_out));

endmodule

bind pll_rate_calc pll_rate_calc_chk #(.Q_W(Q_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .div_word0 (div_word0),
  .busy      (busy_w),
  .valid     (valid),
  .err       (err),
  .freq_out  (freq_out)
);

// File: tb/pll_rate_calc_tb.sv
`timescale 1ns/1ps
module pll_rate_calc_tb;

  localparam int REF_W = 32;
  localparam int Q_W   = 64;
  localparam int LAT   = 64;

  typedef struct packed {
    logic        frac;
    logic [31:0] rf;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [63:0] expv;
    logic [7:0]  req;
  } vec_t;

  // w0 = multiplier<<12 | pre<<4 | post ; w1[15:0] = signed k
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'd24000000,  32'h000E1030, 32'h00000000, 64'd1800000000,   8'd1},
    '{1'b0, 32'd24000000,  32'h000C8031, 32'h00000000, 64'd800000000,    8'd2},
    '{1'b0, 32'd24000000,  32'h000FA022, 32'h00000000, 64'd750000000,    8'd2},
    '{1'b0, 32'd25000000,  32'h00064070, 32'h00000000, 64'd357142857,    8'd2},
    '{1'b0, 32'hFFFFFFFF,  32'h003FF010, 32'h00000000, 64'd4393751542785, 8'd2},
    '{1'b0, 32'd24000000,  32'h003FF3F7, 32'h00000000, 64'd3044642,      8'd2},
    '{1'b1, 32'd24000000,  32'h00106023, 32'h000024DD, 64'd393215995,    8'd3},
    '{1'b1, 32'd24000000,  32'h00145032, 32'h00000000, 64'd650000000,    8'd3},
    '{1'b1, 32'd24000000,  32'h000C6022, 32'h00000000, 64'd594000000,    8'd3},
    '{1'b1, 32'd65536,     32'h00001010, 32'h00008000, 64'd32768,        8'd3},
    '{1'b1, 32'd100000,    32'h00000010, 32'h0000FFFF, 64'hFFFFFFFFFFFFFFFF, 8'd4},
    '{1'b1, 32'd3,         32'h00000010, 32'h00008000, 64'hFFFFFFFFFFFFFFFF, 8'd4},
    '{1'b0, 32'd24000000,  32'hFFCE1C38, 32'h1234FFFF, 64'd1800000000,   8'd11},
    '{1'b1, 32'd24000000,  32'hFFD06C2B, 32'hABCD24DD, 64'd393215995,    8'd12}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              frac_mode;
  logic [REF_W-1:0]  ref_freq;
  logic [31:0]       div_word0;
  logic [31:0]       div_word1;
  logic [Q_W-1:0]    freq_out;
  logic              valid;
  logic              err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_rate_calc #(.REF_W(REF_W), .Q_W(Q_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frac_mode (frac_mode),
    .ref_freq  (ref_freq),
    .div_word0 (div_word0),
    .div_word1 (div_word1),
    .freq_out  (freq_out),
    .valid     (valid),
    .err       (err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // start is sampled by the edge after the first negedge; returns after that edge
  task automatic issue(input logic fm, input logic [31:0] rf, input logic [31:0] w0,
                       input logic [31:0] w1);
    @(negedge clk);
    frac_mode = fm; ref_freq = rf; div_word0 = w0; div_word1 = w1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output int k);
    k = 0;
    while (!valid && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int k;
    int nvalid;
    rst_n = 1'b0; start = 1'b0; frac_mode = 1'b0;
    ref_freq = '0; div_word0 = '0; div_word1 = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", 64'(valid), 64'd0);
    chk("R9 err", 64'(err), 64'd0);
    chk("R9 freq_out", freq_out, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 R2 R3 R4 R11 R12, latency R5
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].frac, VEC[i].rf, VEC[i].w0, VEC[i].w1);
      wait_valid(k);
      chk($sformatf("R5 latency vec%0d", i), 64'(k), 64'(LAT));
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), freq_out, VEC[i].expv);
      @(negedge clk);
      chk($sformatf("R5 one-cycle vec%0d", i), 64'(valid), 64'd0);
    end

    // R8: result holds while idle
    repeat (30) @(negedge clk);
    chk("R8 hold", freq_out, VEC[NV-1].expv);

    // R6: zero pre-divider
    issue(1'b0, 32'd24000000, 32'h000E1000, 32'h0);
    chk("R6 err set", 64'(err), 64'd1);
    chk("R6 no valid", 64'(valid), 64'd0);
    @(negedge clk);
    chk("R6 err one cycle", 64'(err), 64'd0);
    nvalid = 0;
    for (int j = 0; j < 80; j++) begin
      @(negedge clk);
      if (valid) nvalid++;
    end
    chk("R6 no later valid", 64'(nvalid), 64'd0);
    chk("R6 freq unchanged", freq_out, VEC[NV-1].expv);

    // R7: start during a division is ignored
    issue(VEC[0].frac, VEC[0].rf, VEC[0].w0, VEC[0].w1);
    repeat (10) @(negedge clk);
    issue(VEC[1].frac, VEC[1].rf, VEC[1].w0, VEC[1].w1);
    wait_valid(k);
    chk("R7 original timing", 64'(k), 64'(LAT - 12));
    chk("R7 original result", freq_out, VEC[0].expv);
    nvalid = 0;
    for (int j = 0; j < 80; j++) begin
      @(negedge clk);
      if (valid) nvalid++;
    end
    chk("R7 no extra valid", 64'(nvalid), 64'd0);

    // R10: start in the valid cycle is accepted
    issue(VEC[6].frac, VEC[6].rf, VEC[6].w0, VEC[6].w1);
    wait_valid(k);
    chk("R10 first latency", 64'(k), 64'(LAT));
    chk("R10 first result", freq_out, VEC[6].expv);
    frac_mode = VEC[2].frac; ref_freq = VEC[2].rf;
    div_word0 = VEC[2].w0; div_word1 = VEC[2].w1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid(k);
    chk("R10 second latency", 64'(k), 64'(LAT));
    chk("R10 second result", freq_out, VEC[2].expv);

    summary();
    $finish;
  end

endmodule